// File: doc/BRIEF.md
# Bit-Sliced Four-Function Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit built from identical one-bit slices. The default is four slices. Two operand words and a carry input enter the unit. A two-bit function code picks one of four results for every bit: bitwise AND, bitwise OR, bitwise XOR, or the sum of both operands plus the carry input.

Every slice computes all four candidate results at once. It then narrows them to one through a tree of three two-input selectors. The first level of the tree is steered by the upper code bit and the second level by the lower code bit. Each slice feeds its carry to the next slice up. Every slice's carry is a port of its own, and the topmost carry serves as the unit's carry-out. The carry chain runs whatever function is chosen, so the carry outputs always show the carries of the addition. Users read the result through a register of their own after the outputs settle. The block has no clock and no reset.

Top module: `alu4_sliced`

## Requirements
- R1: With sel_i = 2'b00, result_o equals a_i & b_i bit for bit.
- R2: With sel_i = 2'b01, result_o equals a_i | b_i bit for bit.
- R3: With sel_i = 2'b10, result_o equals a_i ^ b_i bit for bit.
- R4: With sel_i = 2'b11, the value {carry_o[WIDTH-1], result_o} equals a_i + b_i + carry_i, treated as unsigned numbers.
- R5: For every function code, carry_o[k] is the majority of a_i[k], b_i[k] and the carry into slice k. The carry into slice 0 is carry_i and the carry into slice k>0 is carry_o[k-1]. So carry_o[k] is bit k+1 of (a_i mod 2^(k+1)) + (b_i mod 2^(k+1)) + carry_i.
- R6: With sel_i = 2'b11, carry_i = 1, a_i = 1 and b_i = 1, result_o[0] is 1, carry_o[0] is 1 and result_o is 4'b0011.
- R7: With sel_i = 2'b11 and the top bit set in both operands, carry_o[WIDTH-1] is 1.
- R8: When only one bit of one operand is set and carry_i is 0, AND yields zero, and OR, XOR and ADD each yield exactly that single bit. No other result bit is affected.
- R9: The outputs depend only on the present inputs. A new input vector is fully reflected at the outputs within the same clock period of the user's sampling register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into the lowest slice |
| sel_i | input | 2 | Function code: 00 AND, 01 OR, 10 XOR, 11 ADD |
| result_o | output | WIDTH | Selected per-bit result |
| carry_o | output | WIDTH | Carry out of each slice; the top bit is the unit carry-out |

## Verification
The assertions are immediate checks evaluated whenever the block's inputs change. They assume every input holds a known 0 or 1, because an unknown operand would make the reference expressions themselves unknown. The bench starts every input at zero and only ever drives integer-derived values. Each vector is held for a full clock period and sampled half a period later, so the checks see only settled values.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_XOR = 2'b10,
    FN_ADD = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_mux2.sv
module alu_mux2 (
  input  logic d0_i,
  input  logic d1_i,
  input  logic s_i,
  output logic y_o
);
  assign y_o = s_i ? d1_i : d0_i;
endmodule

// File: rtl/alu_mux4.sv
// Four-way selector made of three two-way stages: upper code bit first.
module alu_mux4 (
  input  logic       and_i,
  input  logic       or_i,
  input  logic       xor_i,
  input  logic       sum_i,
  input  logic [1:0] sel_i,
  output logic       y_o
);
  logic lo_pick;
  logic hi_pick;

  alu_mux2 u_lvl1_a (.d0_i(and_i), .d1_i(xor_i), .s_i(sel_i[1]), .y_o(lo_pick));
  alu_mux2 u_lvl1_b (.d0_i(or_i),  .d1_i(sum_i), .s_i(sel_i[1]), .y_o(hi_pick));
  alu_mux2 u_lvl2   (.d0_i(lo_pick), .d1_i(hi_pick), .s_i(sel_i[0]), .y_o(y_o));
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic gen;
  logic any_one;

  assign gen     = x_i & y_i;
  assign any_one = x_i | y_i | c_i;
  // Carry from generate or propagated input carry.
  assign c_o = gen | (c_i & (x_i | y_i));
  // Sum: all three set, or at least one set without a carry out.
  assign s_o = (gen & c_i) | (any_one & ~c_o);
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic [1:0] sel_i,
  output logic       f_o,
  output logic       cout_o
);
  logic and_v;
  logic or_v;
  logic xor_v;
  logic sum_v;

  assign and_v = a_i & b_i;
  assign or_v  = a_i | b_i;
  // XOR as the complement of (both set OR neither set).
  assign xor_v = ~(and_v | ~or_v);

  alu_full_adder u_fa (
    .x_i(a_i), .y_i(b_i), .c_i(cin_i), .s_o(sum_v), .c_o(cout_o)
  );

  alu_mux4 u_sel (
    .and_i(and_v), .or_i(or_v), .xor_i(xor_v), .sum_i(sum_v),
    .sel_i(sel_i), .y_o(f_o)
  );
endmodule

// File: rtl/alu4_sliced.sv
module alu4_sliced #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] carry_o
);
  localparam int CHAIN_W = WIDTH + 1;

  logic [CHAIN_W-1:0] chain;

  assign chain[0] = carry_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i   (a_i[k]),
      .b_i   (b_i[k]),
      .cin_i (chain[k]),
      .sel_i (sel_i),
      .f_o   (result_o[k]),
      .cout_o(chain[k+1])
    );
  end

  assign carry_o = chain[CHAIN_W-1:1];
endmodule

// File: rtl/alu4_sliced_chk.sv
module alu4_sliced_chk
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [1:0]       sel_i,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] carry_o
);
  always_comb begin
    case (alu_fn_e'(sel_i))
      FN_AND: a_r1_and_mode: assert (result_o == (a_i & b_i))
                else $error("R1 AND result mismatch");
      FN_OR:  a_r2_or_mode: assert (result_o == (a_i | b_i))
                else $error("R2 OR result mismatch");
      FN_XOR: a_r3_xor_mode: assert (result_o == (a_i ^ b_i))
                else $error("R3 XOR result mismatch");
      default: a_r4_add_mode: assert ({carry_o[WIDTH-1], result_o} ==
                                      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
                else $error("R4 ADD result mismatch");
    endcase
  end

  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      logic cin_k;
      cin_k = (k == 0) ? carry_i : carry_o[k-1];
      a_r5_carry_chain: assert (carry_o[k] ==
                                ((a_i[k] & b_i[k]) | (a_i[k] & cin_k) | (b_i[k] & cin_k)))
        else $error("R5 carry mismatch at slice %0d", k);
    end
  end

  always_comb begin
    if (sel_i == 2'b11 && a_i[WIDTH-1] && b_i[WIDTH-1]) begin
      a_r7_top_carry: assert (carry_o[WIDTH-1])
        else $error("R7 top carry missing");
    end
  end
endmodule

bind alu4_sliced alu4_sliced_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .sel_i(sel_i),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/alu4_sliced_tb_top.sv
`timescale 1ns/1ps
module alu4_sliced_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] res;
  logic [W-1:0] cout;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  alu4_sliced #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .carry_i(cin), .sel_i(sel),
    .result_o(res), .carry_o(cout)
  );

  function automatic logic [W-1:0] exp_carries(int av, int bv, int cv);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      int m = 1 << (k + 1);
      r[k] = (((av % m) + (bv % m) + cv) >> (k + 1)) & 1;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_result(int av, int bv, int cv, int sv);
    case (sv)
      0: return W'(av & bv);
      1: return W'(av | bv);
      2: return W'(av ^ bv);
      default: return W'(av + bv + cv);
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%0d sel=%0d actual=%h expected=%h",
               tag, a, b, cin, sel, act, expv);
    end
  endtask

  task automatic apply(int av, int bv, int cv, int sv);
    @(posedge clk);
    a = W'(av); b = W'(bv); cin = cv[0]; sel = sv[1:0];
    @(negedge clk);
  endtask

  task automatic full_check(int av, int bv, int cv, int sv);
    string rt;
    apply(av, bv, cv, sv);
    case (sv)
      0: rt = "R1";
      1: rt = "R2";
      2: rt = "R3";
      default: rt = "R4";
    endcase
    check({rt, " result"}, res, exp_result(av, bv, cv, sv));
    check("R5 carries", cout, exp_carries(av, bv, cv));
    if (sv == 3)
      check("R4 carry-out", {{(W-1){1'b0}}, cout[W-1]},
            W'((av + bv + cv) >> W));
  endtask

  initial begin
    // R9: reset-free state, all-zero inputs give all-zero outputs
    @(negedge clk);
    check("R9 idle result", res, '0);
    check("R9 idle carries", cout, '0);

    // R8: walking one on each operand for every function
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < W; k++) begin
        apply(1 << k, 0, 0, s);
        check("R8 walk a", res, (s == 0) ? '0 : W'(1 << k));
        check("R8 walk a carries", cout, '0);
        apply(0, 1 << k, 0, s);
        check("R8 walk b", res, (s == 0) ? '0 : W'(1 << k));
      end
    end

    // R6: carry-in with lowest bits set
    apply(1, 1, 1, 3);
    check("R6 result", res, W'(3));
    check("R6 slice0 carry", {{(W-1){1'b0}}, cout[0]}, W'(1));

    // R7: top bits set in both operands
    apply(1 << (W-1), 1 << (W-1), 0, 3);
    check("R7 top carry", {{(W-1){1'b0}}, cout[W-1]}, W'(1));
    check("R7 result", res, '0);

    // R1..R5, R9: exhaustive sweep, one vector per clock period
    for (int s = 0; s < 4; s++)
      for (int av = 0; av < (1 << W); av++)
        for (int bv = 0; bv < (1 << W); bv++)
          for (int cv = 0; cv < 2; cv++)
            full_check(av, bv, cv, s);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule